// File: doc/BRIEF.md
# SECDED Memory ECC with Error Log

This block guards a 64-bit memory data word with 8 check bits, so each stored word is 72 bits wide. On the write side it builds the check bits from the outgoing data. The wide word goes to memory at once, without a register in the path.

On the read side it recomputes the check bits from the returned data. It XORs them with the stored check bits to form an 8-bit syndrome. From that syndrome it repairs any single flipped bit, whether in the data or in the check field. It flags every pattern it cannot repair as uncorrectable.

Each read may carry its column, row, bank and rank. When a read shows an error, those tags and the syndrome go into a one-entry error log. The log follows a fixed priority: an uncorrectable error may displace a logged correctable one, and nothing else displaces a valid entry. Two sticky flags record whether any correctable or uncorrectable error has been seen. A one-cycle clear pulse empties the log and both flags.

Top module: `secded_mem_ecc`

## Requirements
- R1: `wr_word_o[63:0]` equals `wr_data_i` in the same cycle, and check bit k (`wr_word_o[64+k]`) is the XOR of every data bit i whose column code has bit k set. The data column codes are all 8-bit values of weight 3 in ascending order, then the values of weight 5 in ascending order; data bit i takes the i-th value in that list. Check bit k has column code `1<<k`.
- R2: The syndrome is the recomputed check field XOR the stored field `rd_word_i[71:64]`, and it is shown on `out_syndrome_o`. A zero syndrome raises no flag and leaves the data unchanged. A lone flip of bit 64 gives syndrome 0x01.
- R3: When the syndrome equals the column code of position p (0..71), the read is correctable. `out_ce_o` pulses, and if p < 64 then data bit p is inverted on `out_data_o`. A check-bit flip leaves the data as read.
- R4: A non-zero syndrome of even weight sets `out_ue_o`, and `out_data_o` carries the raw data bits.
- R5: A syndrome of odd weight that matches no column code (for example 0xF8 or 0xFE) is also reported on `out_ue_o`, without any correction.
- R6: `out_valid_o`, `out_data_o`, `out_syndrome_o`, `out_ce_o` and `out_ue_o` are registered and belong to the read presented one clock earlier. When `out_valid_o` is low, both `out_ce_o` and `out_ue_o` are low, and data and syndrome hold their last values.
- R7: If the log is empty, an error read stores its column, row, bank, rank and syndrome, sets `log_valid_o`, and sets `log_ue_o` to the error type. The entry is visible in the same cycle as the read's outputs.
- R8: A valid correctable entry is not replaced by a later correctable error. It is replaced by a later uncorrectable error. A valid uncorrectable entry is never replaced.
- R9: When `log_clr_i` is high at an edge, the log entry (all fields zero) and both sticky flags are cleared. An error read at the same edge is recorded as a fresh entry, and its flag is set again.
- R10: While `rst_n` is low, every output register is zero.
- R11: `sts_ce_o` and `sts_ue_o` are set by any correctable or uncorrectable read and stay set until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data_i | input | 64 | Data to be written |
| wr_word_o | output | 72 | Data plus generated check bits |
| rd_valid_i | input | 1 | Read word present this cycle |
| rd_word_i | input | 72 | Stored word returned by memory |
| rd_col_i | input | 10 | Column tag of the read |
| rd_row_i | input | 16 | Row tag of the read |
| rd_bank_i | input | 3 | Bank tag of the read |
| rd_rank_i | input | 2 | Rank tag of the read |
| log_clr_i | input | 1 | One-cycle pulse clearing log and sticky flags |
| out_valid_o | output | 1 | Registered read result valid |
| out_data_o | output | 64 | Corrected data |
| out_syndrome_o | output | 8 | Syndrome of the read |
| out_ce_o | output | 1 | Corrected single-bit error |
| out_ue_o | output | 1 | Uncorrectable error |
| log_valid_o | output | 1 | Log entry present |
| log_ue_o | output | 1 | Logged entry is uncorrectable |
| log_col_o | output | 10 | Logged column |
| log_row_o | output | 16 | Logged row |
| log_bank_o | output | 3 | Logged bank |
| log_rank_o | output | 2 | Logged rank |
| log_syn_o | output | 8 | Logged syndrome |
| sts_ce_o | output | 1 | Sticky correctable-error flag |
| sts_ue_o | output | 1 | Sticky uncorrectable-error flag |

## Verification
The write word is combinational, so it is checked in the same cycle that the write data is driven. Every read result, each log field and both sticky flags are due at the first rising edge after the read is presented. A clear pulse takes effect at that same edge. The bench changes inputs 2 ns after a rising edge, and its model takes the same inputs at the next rising edge, as the registers do. It compares all outputs at the following falling edge, so each expected value lines up with exactly one register stage.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // number of odd-weight codes of weight three or more in a chk_w-bit field
   function automatic int unsigned code_count(input int unsigned chk_w);
      int unsigned n;
      n = 0;
      for (int unsigned v = 0; v < (32'd1 << chk_w); v++) begin
         if (($countones(v) >= 3) && (($countones(v) % 2) == 1)) n++;
      end
      return n;
   endfunction

   // column code of data bit idx: weight 3 ascending, then weight 5, ...
   function automatic int unsigned data_code(input int unsigned chk_w,
                                             input int unsigned idx);
      int unsigned cnt;
      int unsigned res;
      bit          found;
      cnt   = 0;
      res   = 0;
      found = 1'b0;
      for (int unsigned w = 3; w <= chk_w; w += 2) begin
         for (int unsigned v = 0; v < (32'd1 << chk_w); v++) begin
            if (!found && ($countones(v) == w)) begin
               if (cnt == idx) begin
                  res   = v;
                  found = 1'b1;
               end
               cnt++;
            end
         end
      end
      return res;
   endfunction

   // column code of any position in the stored word
   function automatic int unsigned pos_code(input int unsigned chk_w,
                                            input int unsigned data_w,
                                            input int unsigned pos);
      if (pos < data_w) return data_code(chk_w, pos);
      return 32'd1 << (pos - data_w);
   endfunction

endpackage

// File: rtl/secded_chk_gen.sv
module secded_chk_gen #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);

   logic [CHK_W-1:0] term [DATA_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_term
      localparam logic [CHK_W-1:0] CODE =
         CHK_W'(secded_pkg::pos_code(CHK_W, DATA_W, i));
      assign term[i] = data_i[i] ? CODE : '0;
   end

   always_comb begin
      chk_o = '0;
      for (int i = 0; i < DATA_W; i++) chk_o ^= term[i];
   end

endmodule

// File: rtl/secded_syn_dec.sv
module secded_syn_dec #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned WORD_W = DATA_W + CHK_W
) (
   input  logic [CHK_W-1:0]  syn_i,
   output logic [DATA_W-1:0] flip_o,
   output logic              ce_o,
   output logic              ue_o
);

   logic [WORD_W-1:0] hit;

   for (genvar p = 0; p < WORD_W; p++) begin : g_hit
      localparam logic [CHK_W-1:0] CODE =
         CHK_W'(secded_pkg::pos_code(CHK_W, DATA_W, p));
      assign hit[p] = (syn_i == CODE);
   end

   assign flip_o = hit[DATA_W-1:0];
   assign ce_o   = |hit;
   assign ue_o   = (syn_i != '0) && !ce_o;

   always_comb begin
      if (ce_o) begin
         // R3
         single_position_chk: assert ($countones(hit) == 1);
         // R3
         odd_syndrome_chk: assert (($countones(syn_i) % 2) == 1);
      end
   end

endmodule

// File: rtl/secded_err_log.sv
module secded_err_log #(
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned COL_W  = 10,
   parameter int unsigned ROW_W  = 16,
   parameter int unsigned BANK_W = 3,
   parameter int unsigned RANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_ce_i,
   input  logic              ev_ue_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [RANK_W-1:0] rank_i,
   input  logic [CHK_W-1:0]  syn_i,
   input  logic              clr_i,
   output logic              log_valid_o,
   output logic              log_ue_o,
   output logic [COL_W-1:0]  log_col_o,
   output logic [ROW_W-1:0]  log_row_o,
   output logic [BANK_W-1:0] log_bank_o,
   output logic [RANK_W-1:0] log_rank_o,
   output logic [CHK_W-1:0]  log_syn_o,
   output logic              sts_ce_o,
   output logic              sts_ue_o
);

   if (COL_W == 0 || ROW_W == 0 || BANK_W == 0 || RANK_W == 0) begin : g_bad_tag
      $error("secded_err_log: address tag widths must be non-zero");
   end

   logic keep_valid, keep_ue, take_ue, take_ce;

   assign keep_valid = log_valid_o && !clr_i;
   assign keep_ue    = log_ue_o && !clr_i;
   assign take_ue    = ev_ue_i && !(keep_valid && keep_ue);
   assign take_ce    = ev_ce_i && !keep_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_valid_o <= 1'b0;
         log_ue_o    <= 1'b0;
         log_col_o   <= '0;
         log_row_o   <= '0;
         log_bank_o  <= '0;
         log_rank_o  <= '0;
         log_syn_o   <= '0;
      end else if (take_ue || take_ce) begin
         log_valid_o <= 1'b1;
         log_ue_o    <= ev_ue_i;
         log_col_o   <= col_i;
         log_row_o   <= row_i;
         log_bank_o  <= bank_i;
         log_rank_o  <= rank_i;
         log_syn_o   <= syn_i;
      end else if (clr_i) begin
         log_valid_o <= 1'b0;
         log_ue_o    <= 1'b0;
         log_col_o   <= '0;
         log_row_o   <= '0;
         log_bank_o  <= '0;
         log_rank_o  <= '0;
         log_syn_o   <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_ce_o <= 1'b0;
         sts_ue_o <= 1'b0;
      end else begin
         sts_ce_o <= (sts_ce_o && !clr_i) || ev_ce_i;
         sts_ue_o <= (sts_ue_o && !clr_i) || ev_ue_i;
      end
   end

   // R8
   ue_entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid_o && log_ue_o && !clr_i |=>
         log_valid_o && log_ue_o && $stable(log_syn_o) && $stable(log_row_o));

   // R8
   ce_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid_o && !log_ue_o && !clr_i && ev_ce_i && !ev_ue_i |=>
         $stable(log_syn_o) && $stable(log_col_o) && !log_ue_o);

   // R9
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !ev_ce_i && !ev_ue_i |=> !log_valid_o && !sts_ce_o && !sts_ue_o);

endmodule

// File: rtl/secded_mem_ecc.sv
module secded_mem_ecc #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned COL_W  = 10,
   parameter int unsigned ROW_W  = 16,
   parameter int unsigned BANK_W = 3,
   parameter int unsigned RANK_W = 2,
   localparam int unsigned WORD_W = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [WORD_W-1:0] wr_word_o,
   input  logic              rd_valid_i,
   input  logic [WORD_W-1:0] rd_word_i,
   input  logic [COL_W-1:0]  rd_col_i,
   input  logic [ROW_W-1:0]  rd_row_i,
   input  logic [BANK_W-1:0] rd_bank_i,
   input  logic [RANK_W-1:0] rd_rank_i,
   input  logic              log_clr_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic [CHK_W-1:0]  out_syndrome_o,
   output logic              out_ce_o,
   output logic              out_ue_o,
   output logic              log_valid_o,
   output logic              log_ue_o,
   output logic [COL_W-1:0]  log_col_o,
   output logic [ROW_W-1:0]  log_row_o,
   output logic [BANK_W-1:0] log_bank_o,
   output logic [RANK_W-1:0] log_rank_o,
   output logic [CHK_W-1:0]  log_syn_o,
   output logic              sts_ce_o,
   output logic              sts_ue_o
);

   if (CHK_W < 4 || CHK_W > 16) begin : g_bad_chk
      $error("secded_mem_ecc: CHK_W must lie in 4..16");
   end
   if (secded_pkg::code_count(CHK_W) < DATA_W) begin : g_bad_data
      $error("secded_mem_ecc: too few odd-weight column codes for DATA_W");
   end

   // write path
   logic [CHK_W-1:0] wr_chk;

   secded_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wr_gen (
      .data_i (wr_data_i),
      .chk_o  (wr_chk)
   );

   assign wr_word_o = {wr_chk, wr_data_i};

   // read path
   logic [CHK_W-1:0]  rd_chk, syn;
   logic [DATA_W-1:0] flip;
   logic              is_ce, is_ue;

   secded_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rd_gen (
      .data_i (rd_word_i[DATA_W-1:0]),
      .chk_o  (rd_chk)
   );

   assign syn = rd_chk ^ rd_word_i[WORD_W-1:DATA_W];

   secded_syn_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .syn_i  (syn),
      .flip_o (flip),
      .ce_o   (is_ce),
      .ue_o   (is_ue)
   );

   logic ev_ce, ev_ue;
   assign ev_ce = rd_valid_i && is_ce;
   assign ev_ue = rd_valid_i && is_ue;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o    <= 1'b0;
         out_ce_o       <= 1'b0;
         out_ue_o       <= 1'b0;
         out_data_o     <= '0;
         out_syndrome_o <= '0;
      end else begin
         out_valid_o <= rd_valid_i;
         out_ce_o    <= ev_ce;
         out_ue_o    <= ev_ue;
         if (rd_valid_i) begin
            out_data_o     <= rd_word_i[DATA_W-1:0] ^ flip;
            out_syndrome_o <= syn;
         end
      end
   end

   secded_err_log #(
      .CHK_W(CHK_W), .COL_W(COL_W), .ROW_W(ROW_W),
      .BANK_W(BANK_W), .RANK_W(RANK_W)
   ) u_log (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_ce_i     (ev_ce),
      .ev_ue_i     (ev_ue),
      .col_i       (rd_col_i),
      .row_i       (rd_row_i),
      .bank_i      (rd_bank_i),
      .rank_i      (rd_rank_i),
      .syn_i       (syn),
      .clr_i       (log_clr_i),
      .log_valid_o (log_valid_o),
      .log_ue_o    (log_ue_o),
      .log_col_o   (log_col_o),
      .log_row_o   (log_row_o),
      .log_bank_o  (log_bank_o),
      .log_rank_o  (log_rank_o),
      .log_syn_o   (log_syn_o),
      .sts_ce_o    (sts_ce_o),
      .sts_ue_o    (sts_ue_o)
   );

   // R6
   idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> !out_ce_o && !out_ue_o);

   // R3
   ce_ue_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_ce_o && out_ue_o));

   // R2
   clean_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && (out_syndrome_o == '0) |-> !out_ce_o && !out_ue_o);

   // R11
   sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ce_o |-> sts_ce_o) and (out_ue_o |-> sts_ue_o));

endmodule

// File: tb/secded_mem_ecc_tb.sv
`timescale 1ns/1ps
module secded_mem_ecc_tb_top;

   localparam int DW = 64, CW = 8, WW = 72;
   localparam int COLW = 10, ROWW = 16, BW = 3, RKW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [DW-1:0]   wr_data = '0;
   logic [WW-1:0]   wr_word;
   logic            rd_valid = 1'b0;
   logic [WW-1:0]   rd_word = '0;
   logic [COLW-1:0] rd_col = '0;
   logic [ROWW-1:0] rd_row = '0;
   logic [BW-1:0]   rd_bank = '0;
   logic [RKW-1:0]  rd_rank = '0;
   logic            log_clr = 1'b0;
   logic            out_valid, out_ce, out_ue;
   logic [DW-1:0]   out_data;
   logic [CW-1:0]   out_syn;
   logic            log_valid, log_ue, sts_ce, sts_ue;
   logic [COLW-1:0] log_col;
   logic [ROWW-1:0] log_row;
   logic [BW-1:0]   log_bank;
   logic [RKW-1:0]  log_rank;
   logic [CW-1:0]   log_syn;

   secded_mem_ecc #(.DATA_W(DW), .CHK_W(CW), .COL_W(COLW), .ROW_W(ROWW),
                    .BANK_W(BW), .RANK_W(RKW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data), .wr_word_o(wr_word),
      .rd_valid_i(rd_valid), .rd_word_i(rd_word), .rd_col_i(rd_col),
      .rd_row_i(rd_row), .rd_bank_i(rd_bank), .rd_rank_i(rd_rank),
      .log_clr_i(log_clr), .out_valid_o(out_valid), .out_data_o(out_data),
      .out_syndrome_o(out_syn), .out_ce_o(out_ce), .out_ue_o(out_ue),
      .log_valid_o(log_valid), .log_ue_o(log_ue), .log_col_o(log_col),
      .log_row_o(log_row), .log_bank_o(log_bank), .log_rank_o(log_rank),
      .log_syn_o(log_syn), .sts_ce_o(sts_ce), .sts_ue_o(sts_ue)
   );

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   int codes [WW];

   task automatic chk(input string req, input string what,
                      input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] ref_chk(input logic [DW-1:0] d);
      logic [CW-1:0] c;
      c = '0;
      for (int i = 0; i < DW; i++) if (d[i]) c ^= codes[i][CW-1:0];
      return c;
   endfunction

   // reference model, advanced at each rising edge
   bit              started = 1'b0;
   logic            e_valid, e_ce, e_ue, l_valid, l_ue, s_ce, s_ue;
   logic [DW-1:0]   e_data;
   logic [CW-1:0]   e_syn, l_syn, m_syn;
   logic [COLW-1:0] l_col;
   logic [ROWW-1:0] l_row;
   logic [BW-1:0]   l_bank;
   logic [RKW-1:0]  l_rank;
   int              m_pos;
   logic            m_ce, m_ue;

   always @(posedge clk) begin
      started = 1'b1;
      if (!rst_n) begin
         e_valid = 0; e_ce = 0; e_ue = 0; e_data = '0; e_syn = '0;
         l_valid = 0; l_ue = 0; l_col = '0; l_row = '0; l_bank = '0;
         l_rank = '0; l_syn = '0; s_ce = 0; s_ue = 0;
      end else begin
         m_syn = ref_chk(rd_word[DW-1:0]) ^ rd_word[WW-1:DW];
         m_pos = -1;
         for (int p = 0; p < WW; p++)
            if (m_syn != 0 && codes[p] == int'(m_syn)) m_pos = p;
         m_ce = rd_valid && (m_pos >= 0);
         m_ue = rd_valid && (m_syn != 0) && (m_pos < 0);
         e_valid = rd_valid; e_ce = m_ce; e_ue = m_ue;
         if (rd_valid) begin
            e_syn  = m_syn;
            e_data = rd_word[DW-1:0];
            if (m_pos >= 0 && m_pos < DW) e_data[m_pos] = ~e_data[m_pos];
         end
         if (log_clr) begin
            l_valid = 0; l_ue = 0; l_col = '0; l_row = '0; l_bank = '0;
            l_rank = '0; l_syn = '0; s_ce = 0; s_ue = 0;
         end
         if ((m_ue && !(l_valid && l_ue)) || (m_ce && !l_valid)) begin
            l_valid = 1; l_ue = m_ue; l_col = rd_col; l_row = rd_row;
            l_bank = rd_bank; l_rank = rd_rank; l_syn = m_syn;
         end
         s_ce = s_ce | m_ce;
         s_ue = s_ue | m_ue;
      end
   end

   // compare every cycle at the falling edge
   always @(negedge clk) begin
      if (started && !done) begin
         string rq;
         rq = rst_n ? "R1" : "R10";
         chk(rq, "wr_word", wr_word, {ref_chk(wr_data), wr_data});
         rq = rst_n ? "R6" : "R10";
         chk(rq, "out_valid", WW'(out_valid), WW'(e_valid));
         rq = rst_n ? "R3" : "R10";
         chk(rq, "out_data", WW'(out_data), WW'(e_data));
         chk(rq, "out_ce", WW'(out_ce), WW'(e_ce));
         rq = rst_n ? "R2" : "R10";
         chk(rq, "out_syndrome", WW'(out_syn), WW'(e_syn));
         rq = rst_n ? "R4" : "R10";
         chk(rq, "out_ue", WW'(out_ue), WW'(e_ue));
         rq = rst_n ? "R7" : "R10";
         chk(rq, "log_valid", WW'(log_valid), WW'(l_valid));
         chk(rq, "log_addr", WW'({log_col, log_row, log_bank, log_rank}),
             WW'({l_col, l_row, l_bank, l_rank}));
         chk(rq, "log_syn", WW'(log_syn), WW'(l_syn));
         rq = rst_n ? "R8" : "R10";
         chk(rq, "log_ue", WW'(log_ue), WW'(l_ue));
         rq = rst_n ? "R11" : "R10";
         chk(rq, "sticky", WW'({sts_ce, sts_ue}), WW'({s_ce, s_ue}));
      end
   end

   task automatic drive(input bit v, input logic [DW-1:0] d,
                        input logic [WW-1:0] err, input logic [COLW-1:0] col,
                        input bit clr);
      @(posedge clk);
      #2;
      wr_data  = {$urandom, $urandom};
      rd_valid = v;
      rd_word  = {ref_chk(d), d} ^ err;
      rd_col   = col;
      rd_row   = ROWW'($urandom);
      rd_bank  = BW'($urandom);
      rd_rank  = RKW'($urandom);
      log_clr  = clr;
   endtask

   task automatic rd(input logic [DW-1:0] d, input logic [WW-1:0] err,
                     input logic [COLW-1:0] col);
      drive(1'b1, d, err, col, 1'b0);
   endtask

   task automatic idle();
      drive(1'b0, '0, '0, '0, 1'b0);
   endtask

   task automatic clear();
      drive(1'b0, '0, '0, '0, 1'b1);
   endtask

   function automatic logic [WW-1:0] one(input int p);
      return WW'(1) << p;
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int n;
      n = 0;
      for (int w = 3; w <= CW; w += 2)
         for (int v = 0; v < 256; v++)
            if ($countones(v) == w && n < DW) begin
               codes[n] = v;
               n++;
            end
      for (int k = 0; k < CW; k++) codes[DW+k] = 1 << k;

      // R10: reset state, compared by the model loop
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;

      // R2: clean reads and a CB0 flip
      for (int i = 0; i < 6; i++) rd({$urandom, $urandom}, '0, 10'(i));
      rd(64'h0123_4567_89ab_cdef, one(64), 10'd7);
      idle();
      @(negedge clk);
      chk("R2", "cb0 syndrome", WW'(log_syn), WW'(8'h01));
      clear();

      // R3: every single-bit position
      for (int p = 0; p < WW; p++) rd({$urandom, $urandom}, one(p), 10'(p));
      clear();

      // R8: ce then ce keeps first; ue replaces; later ce and ue do not
      rd(64'hffff_0000_ffff_0000, one(3), 10'd100);
      rd(64'h1111_2222_3333_4444, one(40), 10'd200);
      idle();
      @(negedge clk);
      chk("R8", "first ce kept", WW'(log_col), WW'(10'd100));
      rd(64'h5555_aaaa_5555_aaaa, one(1) | one(9), 10'd300);
      rd(64'h0, one(5), 10'd400);
      rd(64'h0, one(10) | one(70), 10'd500);
      idle();
      @(negedge clk);
      chk("R8", "ue replaced ce and held", WW'({log_ue, log_col}), WW'({1'b1, 10'd300}));

      // R9: clear alone, then clear together with an error
      clear();
      idle();
      @(negedge clk);
      chk("R9", "log empty after clear", WW'({log_valid, sts_ce, sts_ue}), '0);
      rd(64'h0, one(2) | one(4), 10'd600);
      drive(1'b1, 64'h0, one(20), 10'd601, 1'b1);
      idle();
      @(negedge clk);
      chk("R9", "clear with capture", WW'({log_valid, log_ue, log_col, sts_ue}),
          WW'({1'b1, 1'b0, 10'd601, 1'b0}));
      clear();

      // R5: odd-weight syndromes that name no position
      rd(64'hdead_beef_0000_1234, one(67) | one(68) | one(69) | one(70) | one(71), 10'd700);
      idle();
      @(negedge clk);
      chk("R5", "syndrome f8 uncorrectable", WW'({log_ue, log_syn}), WW'({1'b1, 8'hf8}));
      clear();
      rd(64'h0, one(65) | one(66) | one(67) | one(68) | one(69) | one(70) | one(71), 10'd701);
      idle();
      @(negedge clk);
      chk("R5", "syndrome fe uncorrectable", WW'({log_ue, log_syn}), WW'({1'b1, 8'hfe}));

      // R6 / R4 / R11: random traffic with gaps and occasional clears
      for (int i = 0; i < 2000; i++) begin
         int kind, p1, p2;
         logic [WW-1:0] e;
         kind = $urandom % 4;
         p1 = $urandom % WW;
         p2 = (p1 + 1 + ($urandom % (WW - 1))) % WW;
         e = '0;
         if (kind == 1) e = one(p1);
         if (kind == 2) e = one(p1) | one(p2);
         drive(($urandom % 4) != 0, {$urandom, $urandom}, e,
               COLW'($urandom), ($urandom % 50) == 0);
      end
      idle();
      idle();
      @(negedge clk);
      finish_run();
   end

endmodule